// File: doc/BRIEF.md
# Weekly Minute Alarm Comparator

This block watches a running calendar clock, given as BCD seconds, BCD minutes, BCD hours and a binary weekday from 0 to 6. It compares that time against a programmed alarm minute, alarm hour and a seven-bit weekday mask. The comparison is made once per minute, at the moment the seconds count wraps to 00. A single alarm can therefore fire on one chosen day or on any set of days in the week. Because the resolution is one minute and days are chosen by weekday, an alarm can be placed no more than one week ahead.

On a match with the alarm enabled, a sticky event flag is set. The flag stays set until a clear strobe removes it. The interrupt line either follows the flag, masked by the enable, or gives a single-cycle pulse for each event. Software programs the block through a byte-wide write port with a two-bit register select.

Top module: `wk_alarm_top`

## Requirements
- R1: After reset the alarm minute, hour and weekday mask are all zero, the enable and mode bits are zero, and the event flag and interrupt are low.
- R2: A match needs three things: the BCD minute equals the alarm minute, the BCD hour equals the alarm hour, and bit `weekday` of the mask is set. The flag rises in the cycle after the evaluation cycle.
- R3: A match is evaluated only in a cycle where the seconds input is 00 and was non-zero in the previous cycle. Seconds held at 00 give one event, and a matching time with non-zero seconds gives none.
- R4: Several mask bits may be set, and each selected weekday matches. A mask of all zeros never matches.
- R5: Bit 4 of the control register is the alarm enable. A match while it is 0 leaves the flag unchanged.
- R6: The flag stays high until a cycle with `clrFlag` high, which clears it at the next edge. If a new match comes in the same cycle as the clear, the flag stays set.
- R7: With control bit 0 at 0 (level mode), `almIrq` equals the flag ANDed with the enable. Clearing the enable masks the interrupt but keeps the flag.
- R8: With control bit 0 at 1 (pulse mode), `almIrq` is high for exactly one cycle: the cycle after an enabled match.
- R9: Write select codes: 0 = alarm minute (BCD), 1 = alarm hour (BCD), 2 = weekday mask (data bits 6:0, bit n selects weekday n), 3 = control. A write takes effect at the clock edge where `cfgWe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgSel | input | 2 | Register select (0 min, 1 hour, 2 mask, 3 control) |
| cfgData | input | 8 | Write data |
| clrFlag | input | 1 | Clears the event flag |
| secNow | input | 8 | Current seconds, BCD |
| minNow | input | 8 | Current minute, BCD |
| hourNow | input | 8 | Current hour, BCD |
| wdayNow | input | 3 | Current weekday, 0 to 6 |
| almFlag | output | 1 | Sticky alarm event flag |
| almIrq | output | 1 | Interrupt (level or pulse) |

## Verification
Each kind of internal fault shows up at the ports within one clock of the minute rollover that exposes it. A corrupt alarm register or mask shows as a missing or spurious `almFlag` at that rollover. A broken rollover detector shows as repeated or absent events while the seconds sit at 00. A wrong mode or enable bit shows as an interrupt that stays high in pulse mode, or that leaks through while the enable is low. The bench fires each scenario and samples one edge after the evaluation cycle. In pulse mode it also samples the edge after that.

// File: rtl/wk_alarm_pkg.sv
package wk_alarm_pkg;
  localparam int BCD_W  = 8;
  localparam int DAYS   = 7;
  localparam int WDAY_W = 3;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_MIN  = 2'd0,
    SEL_HOUR = 2'd1,
    SEL_MASK = 2'd2,
    SEL_CTL  = 2'd3
  } regSelT;

  typedef struct packed {
    logic wrMin;
    logic wrHour;
    logic wrMask;
  } dpStrobeT;
endpackage

// File: rtl/wk_alarm_dp.sv
module wk_alarm_dp
  import wk_alarm_pkg::*;
#(
  parameter int BCDW = BCD_W,
  parameter int NDAY = DAYS,
  parameter int WDW  = WDAY_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobeT        stb,
  input  logic [BCDW-1:0] wrData,
  input  logic [BCDW-1:0] secNow,
  input  logic [BCDW-1:0] minNow,
  input  logic [BCDW-1:0] hourNow,
  input  logic [WDW-1:0]  wdayNow,
  output logic            hitOut
);
  logic [BCDW-1:0] almMinQ, almHourQ, prevSecQ;
  logic [NDAY-1:0] dayMaskQ, wdayDec;
  logic            rollEvt, timeEq, dayEq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      almMinQ  <= '0;
      almHourQ <= '0;
      dayMaskQ <= '0;
      prevSecQ <= '0;
    end else begin
      prevSecQ <= secNow;
      if (stb.wrMin)  almMinQ  <= wrData;
      if (stb.wrHour) almHourQ <= wrData;
      if (stb.wrMask) dayMaskQ <= wrData[NDAY-1:0];
    end
  end

  // one-hot decode of the running weekday; codes >= NDAY decode to nothing
  for (genvar d = 0; d < NDAY; d++) begin : g_dec
    assign wdayDec[d] = (wdayNow == WDW'(d));
  end

  assign rollEvt = (secNow == '0) && (prevSecQ != '0);
  assign timeEq  = (minNow == almMinQ) && (hourNow == almHourQ);
  assign dayEq   = |(dayMaskQ & wdayDec);
  assign hitOut  = rollEvt && timeEq && dayEq;

  AST_ONE_ROLL: assert property (@(posedge clk) disable iff (!rstN)
    rollEvt |=> !rollEvt); // R3
  AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (dayMaskQ == '0) |-> !hitOut); // R4
  AST_NONZERO_SEC: assert property (@(posedge clk) disable iff (!rstN)
    (secNow != '0) |-> !hitOut); // R3
endmodule

// File: rtl/wk_alarm_ctl.sv
module wk_alarm_ctl
  import wk_alarm_pkg::*;
#(
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [SW-1:0] cfgSel,
  input  logic          enBit,
  input  logic          modeBit,
  input  logic          clrFlag,
  input  logic          hitIn,
  output dpStrobeT      stb,
  output logic          flagO,
  output logic          irqO
);
  logic enQ, pulseQ, flagQ, irqPulseQ, wrCtl, setFlag;

  always_comb begin
    stb   = '0;
    wrCtl = 1'b0;
    if (cfgWe) begin
      unique case (regSelT'(cfgSel))
        SEL_MIN:  stb.wrMin  = 1'b1;
        SEL_HOUR: stb.wrHour = 1'b1;
        SEL_MASK: stb.wrMask = 1'b1;
        SEL_CTL:  wrCtl      = 1'b1;
        default:  ;
      endcase
    end
  end

  assign setFlag = hitIn && enQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ       <= 1'b0;
      pulseQ    <= 1'b0;
      flagQ     <= 1'b0;
      irqPulseQ <= 1'b0;
    end else begin
      if (wrCtl) begin
        enQ    <= enBit;
        pulseQ <= modeBit;
      end
      if (setFlag)      flagQ <= 1'b1;
      else if (clrFlag) flagQ <= 1'b0;
      irqPulseQ <= setFlag && pulseQ;
    end
  end

  assign flagO = flagQ;
  assign irqO  = pulseQ ? irqPulseQ : (flagQ && enQ);

  AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (!flagQ && hitIn && !enQ) |=> !flagQ); // R5
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (clrFlag && !hitIn) |=> !flagQ); // R6
  AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (hitIn && enQ) |=> flagQ); // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulseQ |=> !irqPulseQ); // R8
endmodule

// File: rtl/wk_alarm_top.sv
module wk_alarm_top
  import wk_alarm_pkg::*;
#(
  parameter int BCDW = BCD_W,
  parameter int NDAY = DAYS,
  parameter int WDW  = WDAY_W,
  parameter int SW   = SEL_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWe,
  input  logic [SW-1:0]   cfgSel,
  input  logic [BCDW-1:0] cfgData,
  input  logic            clrFlag,
  input  logic [BCDW-1:0] secNow,
  input  logic [BCDW-1:0] minNow,
  input  logic [BCDW-1:0] hourNow,
  input  logic [WDW-1:0]  wdayNow,
  output logic            almFlag,
  output logic            almIrq
);
  localparam int EN_POS   = 4;
  localparam int MODE_POS = 0;

  dpStrobeT stb;
  logic     hit;

  wk_alarm_ctl #(.SW(SW)) u_ctl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .enBit(cfgData[EN_POS]), .modeBit(cfgData[MODE_POS]),
    .clrFlag(clrFlag), .hitIn(hit), .stb(stb),
    .flagO(almFlag), .irqO(almIrq)
  );

  wk_alarm_dp #(.BCDW(BCDW), .NDAY(NDAY), .WDW(WDW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(cfgData),
    .secNow(secNow), .minNow(minNow), .hourNow(hourNow),
    .wdayNow(wdayNow), .hitOut(hit)
  );
endmodule

// File: tb/wk_alarm_top_test.sv
module wk_alarm_top_test;
  logic clk = 1'b0, rstN = 1'b0, cfgWe = 1'b0, clrFlag = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [7:0] cfgData = '0, secNow = 8'h59, minNow = '0, hourNow = '0;
  logic [2:0] wdayNow = '0;
  logic almFlag, almIrq;
  int nChk = 0, nBad = 0;

  always #2 clk = ~clk;

  wk_alarm_top uut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); cfgWe = 1'b1; cfgSel = sel; cfgData = d;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk); clrFlag = 1'b1;
    @(negedge clk); clrFlag = 1'b0;
  endtask

  // seconds 59 then 00 at the given time; returns at the negedge after evaluation
  task automatic fire(input logic [7:0] m, input logic [7:0] h,
                      input logic [2:0] wd, input logic clr);
    @(negedge clk); secNow = 8'h59; minNow = m; hourNow = h; wdayNow = wd;
    @(negedge clk); secNow = 8'h00; clrFlag = clr;
    @(negedge clk); clrFlag = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 flag", almFlag, 1'b0);
    chk("R1 irq", almIrq, 1'b0);
    wr(2'd3, 8'h10);
    fire(8'h00, 8'h00, 3'd0, 1'b0);
    chk("R1 zero regs no match", almFlag, 1'b0);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_basic();
    wr(2'd0, 8'h30); wr(2'd1, 8'h14); wr(2'd2, 8'h08); wr(2'd3, 8'h10);
    fire(8'h30, 8'h14, 3'd3, 1'b0);
    chk("R2 R9 match flag", almFlag, 1'b1);
    chk("R7 level irq", almIrq, 1'b1);
    clear();
    chk("R6 cleared", almFlag, 1'b0);
    fire(8'h31, 8'h14, 3'd3, 1'b0);
    chk("R2 wrong minute", almFlag, 1'b0);
    fire(8'h30, 8'h15, 3'd3, 1'b0);
    chk("R2 wrong hour", almFlag, 1'b0);
    fire(8'h30, 8'h14, 3'd2, 1'b0);
    chk("R2 wrong day", almFlag, 1'b0);
  endtask

  task automatic t_held();
    fire(8'h30, 8'h14, 3'd3, 1'b0);
    clear();
    repeat (5) @(negedge clk);
    chk("R3 held at 00 single event", almFlag, 1'b0);
    for (int s = 1; s < 6; s++) begin
      @(negedge clk); secNow = 8'(s);
    end
    @(negedge clk);
    chk("R3 nonzero seconds no event", almFlag, 1'b0);
  endtask

  task automatic t_mask();
    wr(2'd2, 8'h41);
    fire(8'h30, 8'h14, 3'd6, 1'b0);
    chk("R4 day6 of mask", almFlag, 1'b1);
    clear();
    fire(8'h30, 8'h14, 3'd0, 1'b0);
    chk("R4 day0 of mask", almFlag, 1'b1);
    clear();
    fire(8'h30, 8'h14, 3'd1, 1'b0);
    chk("R4 day1 not in mask", almFlag, 1'b0);
    wr(2'd2, 8'h00);
    fire(8'h30, 8'h14, 3'd0, 1'b0);
    chk("R4 empty mask", almFlag, 1'b0);
    wr(2'd2, 8'h08);
  endtask

  task automatic t_enable();
    wr(2'd3, 8'h00);
    fire(8'h30, 8'h14, 3'd3, 1'b0);
    chk("R5 disabled no flag", almFlag, 1'b0);
    wr(2'd3, 8'h10);
    fire(8'h30, 8'h14, 3'd3, 1'b0);
    chk("R5 enabled flag", almFlag, 1'b1);
    wr(2'd3, 8'h00);
    chk("R7 masked irq", almIrq, 1'b0);
    chk("R7 flag kept", almFlag, 1'b1);
    wr(2'd3, 8'h10);
    chk("R7 irq returns", almIrq, 1'b1);
    clear();
    chk("R7 irq low after clear", almIrq, 1'b0);
  endtask

  task automatic t_pulse();
    wr(2'd3, 8'h11);
    fire(8'h30, 8'h14, 3'd3, 1'b0);
    chk("R8 pulse high", almIrq, 1'b1);
    chk("R8 flag set", almFlag, 1'b1);
    @(negedge clk);
    chk("R8 pulse one cycle", almIrq, 1'b0);
    chk("R8 flag sticky", almFlag, 1'b1);
    clear();
    wr(2'd3, 8'h10);
  endtask

  task automatic t_coincide();
    fire(8'h30, 8'h14, 3'd3, 1'b0);
    fire(8'h30, 8'h14, 3'd3, 1'b1);
    chk("R6 set beats clear", almFlag, 1'b1);
    clear();
    chk("R6 clear after", almFlag, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_held();
    t_mask();
    t_enable();
    t_pulse();
    t_coincide();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    #200000;
    nChk++; nBad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule